// File: doc/BRIEF.md
# AXI4-Lite to APB Bridge with Error Mapping

This block sits between an AXI4-Lite manager and a set of APB peripherals. It takes one read or one write at a time from the AXI4-Lite side, decodes the address against a parameterized row of peripheral windows and runs the access as a two-phase APB transfer: a setup cycle, then access cycles until the peripheral signals ready. The result goes back as a single beat on the write-response channel for writes or on the read-data channel for reads.

Errors come from two sources, and each is reported with its own code. An address that falls outside every window is answered by the bridge itself with a decode-error code. No peripheral select is raised for it. A peripheral that flags a fault when its transfer completes gets a slave-error code. Because only one transaction is in flight, and the code is captured at that transaction's completion edge, every code belongs to the access that produced it.

Window k covers the addresses whose upper bits (above `SLOT_LOG`) equal k and whose offset within the slot is below `SPAN`, for k from 0 to `N_SLV`-1. With the default parameters the windows are 0x0000-0x03FF, 0x1000-0x13FF and 0x2000-0x23FF.

Top module: `axil_apb_bridge`

## Requirements
- R1: Response codes are 2'b00 for OKAY, 2'b10 for slave error and 2'b11 for decode error. A transfer that completes with `apb_ready`=1 and `apb_fault`=0 returns 2'b00.
- R2: `apb_fault` is looked at only in the access cycle where `apb_ready` is 1. A fault level present during wait cycles (access with `apb_ready`=0) has no effect on the code.
- R3: A completion with `apb_fault`=1 returns 2'b10 on `b_resp` for a write or on `r_resp` for a read. The next transaction still gets its own code.
- R4: An address inside window k raises only `apb_sel[k]`. An address outside every window returns 2'b11, with `r_data` all zeros for a read, and no `apb_sel` bit rises.
- R5: Each APB transfer is one cycle with `apb_sel` high and `apb_enable` low, then access cycles with `apb_enable` high. `apb_addr`, `apb_write` and `apb_wdata` hold the transaction's values.
- R6: A write does not start on APB until both its address and its data have been accepted.
- R7: When a read and a write are both waiting, they are served alternately, and a read goes first after reset.
- R8: `b_valid` or `r_valid` stays high until `b_ready` or `r_ready` is seen. The code, and for reads the data, hold steady meanwhile.
- R9: A read returns the `apb_rdata` value present at its completion edge, even when that completion carries a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address slot free |
| aw_addr | input | ADDR_W | Write address |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data slot free |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write byte strobes |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response accepted |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address slot free |
| ar_addr | input | ADDR_W | Read address |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data accepted |
| r_data | output | DATA_W | Read data |
| r_resp | output | 2 | Read response code |
| apb_sel | output | N_SLV | One select per peripheral window |
| apb_enable | output | 1 | Access phase marker |
| apb_write | output | 1 | Transfer direction, 1 for write |
| apb_addr | output | ADDR_W | Transfer address |
| apb_wdata | output | DATA_W | Write data to peripheral |
| apb_strb | output | DATA_W/8 | Byte strobes to peripheral |
| apb_rdata | input | DATA_W | Read data from selected peripheral |
| apb_ready | input | 1 | Peripheral completes the access |
| apb_fault | input | 1 | Peripheral error flag at completion |

## Verification
The arbitration order is the hardest behaviour to reach from the ports. It only shows when a read and a write are both queued at the moment the bridge goes idle, and a fresh bridge normally starts the first queued item at once. The stimulus gets there by first presenting a read and a write on the same cycle after reset. It then holds `r_ready` low on a read response, loads a new write and a new read into the free slots while that response is held, and releases it. The order of `apb_write` values at each completion then shows which request won. The fault-during-wait case is reached by having the peripheral model drive `apb_fault` high in every wait cycle and low only at completion.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    RC_OKAY   = 2'b00,
    RC_EXOKAY = 2'b01,
    RC_SLVERR = 2'b10,
    RC_DECERR = 2'b11
  } rcode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_RESP
  } bstate_t;

endpackage

// File: rtl/bridge_req_slot.sv
module bridge_req_slot #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             take,
  output logic             full,
  output logic [WIDTH-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  assign in_ready = !full;

  p_take_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> full);

endmodule

// File: rtl/bridge_addr_dec.sv
module bridge_addr_dec #(
  parameter int ADDR_W   = 16,
  parameter int N_SLV    = 3,
  parameter int SLOT_LOG = 12,
  parameter int SPAN     = 1024
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SLV-1:0]  sel,
  output logic              hit
);

  localparam int SLOT_W = ADDR_W - SLOT_LOG;
  localparam logic [SLOT_LOG:0] SPAN_V = (SLOT_LOG+1)'(SPAN);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_LOG:0] off;

  assign slot = addr[ADDR_W-1:SLOT_LOG];
  assign off  = {1'b0, addr[SLOT_LOG-1:0]};

  for (genvar k = 0; k < N_SLV; k++) begin : g_win
    assign sel[k] = (slot == SLOT_W'(k)) && (off < SPAN_V);
  end

  assign hit = |sel;

  always_comb begin
    p_one_window_r4: assert ($onehot0(sel));
  end

endmodule

// File: rtl/bridge_rr_arb.sv
module bridge_rr_arb (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req_rd,
  input  logic req_wr,
  output logic gnt_rd,
  output logic gnt_wr
);

  logic last_wr;

  always_comb begin
    gnt_rd = 1'b0;
    gnt_wr = 1'b0;
    if (enable) begin
      if (req_rd && req_wr) begin
        gnt_wr = !last_wr;
        gnt_rd = last_wr;
      end else begin
        gnt_rd = req_rd;
        gnt_wr = req_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  last_wr <= 1'b1;
    else if (gnt_rd || gnt_wr) last_wr <= gnt_wr;
  end

  p_grant_backed_r7: assert property (@(posedge clk) disable iff (rst)
    (gnt_rd |-> req_rd) and (gnt_wr |-> req_wr));

  p_grant_single_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_rd, gnt_wr}));

  p_alternate_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && req_rd && req_wr && gnt_wr) |=> last_wr);

endmodule

// File: rtl/axil_apb_bridge.sv
module axil_apb_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int N_SLV    = 3,
  parameter int SLOT_LOG = 12,
  parameter int SPAN     = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                aw_valid,
  output logic                aw_ready,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  output logic                b_valid,
  input  logic                b_ready,
  output logic [1:0]          b_resp,
  input  logic                ar_valid,
  output logic                ar_ready,
  input  logic [ADDR_W-1:0]   ar_addr,
  output logic                r_valid,
  input  logic                r_ready,
  output logic [DATA_W-1:0]   r_data,
  output logic [1:0]          r_resp,
  output logic [N_SLV-1:0]    apb_sel,
  output logic                apb_enable,
  output logic                apb_write,
  output logic [ADDR_W-1:0]   apb_addr,
  output logic [DATA_W-1:0]   apb_wdata,
  output logic [DATA_W/8-1:0] apb_strb,
  input  logic [DATA_W-1:0]   apb_rdata,
  input  logic                apb_ready,
  input  logic                apb_fault
);

  localparam int STRB_W = DATA_W / 8;
  localparam int WPK_W  = DATA_W + STRB_W;

  bstate_t state;

  logic              aw_full, w_full, ar_full;
  logic [ADDR_W-1:0] aw_q, ar_q;
  logic [WPK_W-1:0]  wpk_q;
  logic              gnt_rd, gnt_wr, grant;
  logic [ADDR_W-1:0] pick_addr;
  logic [N_SLV-1:0]  dec_sel;
  logic              dec_hit;
  logic              cur_wr;
  rcode_t            code_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done;

  bridge_req_slot #(.WIDTH(ADDR_W)) u_aw_slot (
    .clk(clk), .rst(rst), .in_valid(aw_valid), .in_ready(aw_ready),
    .in_data(aw_addr), .take(gnt_wr), .full(aw_full), .data(aw_q)
  );

  bridge_req_slot #(.WIDTH(WPK_W)) u_w_slot (
    .clk(clk), .rst(rst), .in_valid(w_valid), .in_ready(w_ready),
    .in_data({w_strb, w_data}), .take(gnt_wr), .full(w_full), .data(wpk_q)
  );

  bridge_req_slot #(.WIDTH(ADDR_W)) u_ar_slot (
    .clk(clk), .rst(rst), .in_valid(ar_valid), .in_ready(ar_ready),
    .in_data(ar_addr), .take(gnt_rd), .full(ar_full), .data(ar_q)
  );

  bridge_rr_arb u_arb (
    .clk(clk), .rst(rst), .enable(state == ST_IDLE),
    .req_rd(ar_full), .req_wr(aw_full && w_full),
    .gnt_rd(gnt_rd), .gnt_wr(gnt_wr)
  );

  assign grant     = gnt_rd || gnt_wr;
  assign pick_addr = gnt_wr ? aw_q : ar_q;

  bridge_addr_dec #(
    .ADDR_W(ADDR_W), .N_SLV(N_SLV), .SLOT_LOG(SLOT_LOG), .SPAN(SPAN)
  ) u_dec (
    .addr(pick_addr), .sel(dec_sel), .hit(dec_hit)
  );

  assign done = (state == ST_RESP) && (cur_wr ? b_ready : r_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_wr     <= 1'b0;
      code_q     <= RC_OKAY;
      rdata_q    <= '0;
      apb_sel    <= '0;
      apb_enable <= 1'b0;
      apb_write  <= 1'b0;
      apb_addr   <= '0;
      apb_wdata  <= '0;
      apb_strb   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (grant) begin
            cur_wr    <= gnt_wr;
            apb_write <= gnt_wr;
            apb_addr  <= pick_addr;
            if (gnt_wr) begin
              apb_wdata <= wpk_q[DATA_W-1:0];
              apb_strb  <= wpk_q[WPK_W-1:DATA_W];
            end else begin
              apb_strb  <= '0;
            end
            if (dec_hit) begin
              apb_sel <= dec_sel;
              state   <= ST_SETUP;
            end else begin
              code_q  <= RC_DECERR;
              rdata_q <= '0;
              state   <= ST_RESP;
            end
          end
        end
        ST_SETUP: begin
          apb_enable <= 1'b1;
          state      <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (apb_ready) begin
            apb_sel    <= '0;
            apb_enable <= 1'b0;
            code_q     <= apb_fault ? RC_SLVERR : RC_OKAY;
            if (!cur_wr) rdata_q <= apb_rdata;
            state      <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign b_valid = (state == ST_RESP) && cur_wr;
  assign r_valid = (state == ST_RESP) && !cur_wr;
  assign b_resp  = code_q;
  assign r_resp  = code_q;
  assign r_data  = rdata_q;

  p_hold_b_r8: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));

  p_hold_r_r8: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_resp) && $stable(r_data)));

  p_clean_okay_r1: assert property (@(posedge clk) disable iff (rst)
    (apb_enable && apb_ready && !apb_fault) |=>
      ((b_valid && b_resp == 2'b00) || (r_valid && r_resp == 2'b00)));

  p_fault_slverr_r3: assert property (@(posedge clk) disable iff (rst)
    (apb_enable && apb_ready && apb_fault) |=>
      ((b_valid && b_resp == 2'b10) || (r_valid && r_resp == 2'b10)));

  p_setup_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(apb_enable) |-> ($past(|apb_sel) && $stable(apb_sel) && $stable(apb_addr)));

  p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ((b_valid || r_valid) && code_q == RC_DECERR) |-> (apb_sel == '0));

  p_sel_single_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(apb_sel));

  p_read_data_r9: assert property (@(posedge clk) disable iff (rst)
    (apb_enable && apb_ready && !apb_write) |=> (r_data == $past(apb_rdata)));

endmodule

// File: tb/axil_apb_bridge_tb_top.sv
module axil_apb_bridge_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          aw_valid = 0, w_valid = 0, ar_valid = 0;
  logic          b_ready = 1, r_ready = 1;
  logic [AW-1:0] aw_addr = '0, ar_addr = '0;
  logic [DW-1:0] w_data = '0;
  logic [3:0]    w_strb = '0;
  logic          aw_ready, w_ready, ar_ready, b_valid, r_valid;
  logic [1:0]    b_resp, r_resp;
  logic [DW-1:0] r_data;
  logic [NS-1:0] apb_sel;
  logic          apb_enable, apb_write;
  logic [AW-1:0] apb_addr;
  logic [DW-1:0] apb_wdata;
  logic [3:0]    apb_strb;
  logic [DW-1:0] apb_rdata = '0;
  logic          apb_ready = 0, apb_fault = 0;

  axil_apb_bridge dut_i (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
    .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_strb(apb_strb),
    .apb_rdata(apb_rdata), .apb_ready(apb_ready), .apb_fault(apb_fault)
  );

  // peripheral model configuration
  logic [1:0]    cfg_waits = 0;
  logic          cfg_err = 0, cfg_noise = 0;
  logic [DW-1:0] cfg_rd = '0;
  // monitor records
  int            sel_cycles = 0, setup_cycles = 0, wcnt = 0, ord_n = 0;
  logic [NS-1:0] cap_sel;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wdata;
  logic          cap_wr;
  logic          ord_log [0:15];

  initial begin
    forever begin
      @(negedge clk);
      if (|apb_sel) sel_cycles++;
      if (|apb_sel && !apb_enable) setup_cycles++;
      if (|apb_sel && apb_enable) begin
        if (wcnt == int'(cfg_waits)) begin
          apb_ready = 1; apb_fault = cfg_err; apb_rdata = cfg_rd;
          cap_sel = apb_sel; cap_addr = apb_addr; cap_wdata = apb_wdata;
          cap_wr = apb_write; ord_log[ord_n[3:0]] = apb_write; ord_n++;
          wcnt = 0;
        end else begin
          apb_ready = 0; apb_fault = cfg_noise; apb_rdata = 32'hBAD0_BAD0;
          wcnt++;
        end
      end else begin
        apb_ready = 0; apb_fault = 0;
      end
    end
  end

  int checks = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input bit do_aw, input bit do_w, input bit do_ar,
                         input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                         input logic [AW-1:0] ra);
    @(negedge clk);
    aw_valid = do_aw; aw_addr = wa;
    w_valid = do_w; w_data = wd; w_strb = 4'hF;
    ar_valid = do_ar; ar_addr = ra;
    while ((do_aw && !aw_ready) || (do_w && !w_ready) || (do_ar && !ar_ready))
      @(negedge clk);
    @(negedge clk);
    aw_valid = 0; w_valid = 0; ar_valid = 0;
  endtask

  typedef struct packed {
    logic          wr;
    logic [15:0]   addr;
    logic [31:0]   data;
    logic [1:0]    waits;
    logic          err;
    logic          noise;
    logic [1:0]    resp;
    logic [2:0]    sel;
  } vec_t;

  // R1 clean, R2 noise during waits, R3 fault, R4 windows and misses, R9 read data
  localparam vec_t VECS [9] = '{
    vec_t'{1'b1, 16'h0010, 32'hA5A5_0001, 2'd0, 1'b0, 1'b0, 2'b00, 3'b001},
    vec_t'{1'b0, 16'h1020, 32'h1234_5678, 2'd1, 1'b0, 1'b0, 2'b00, 3'b010},
    vec_t'{1'b1, 16'h2004, 32'h0BAD_0002, 2'd2, 1'b1, 1'b0, 2'b10, 3'b100},
    vec_t'{1'b0, 16'h2100, 32'hDEAD_0003, 2'd0, 1'b1, 1'b0, 2'b10, 3'b100},
    vec_t'{1'b0, 16'h0000, 32'h0000_C0DE, 2'd2, 1'b0, 1'b1, 2'b00, 3'b001},
    vec_t'{1'b1, 16'h0400, 32'h5555_0005, 2'd0, 1'b0, 1'b0, 2'b11, 3'b000},
    vec_t'{1'b0, 16'h3000, 32'h7777_0006, 2'd0, 1'b0, 1'b0, 2'b11, 3'b000},
    vec_t'{1'b1, 16'h13FC, 32'h0F0F_0007, 2'd1, 1'b0, 1'b0, 2'b00, 3'b010},
    vec_t'{1'b0, 16'h03FC, 32'h8888_0008, 2'd3, 1'b0, 1'b0, 2'b00, 3'b001}
  };

  task automatic wait_resp(input bit wr);
    while (wr ? !b_valid : !r_valid) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int s0, u0, o0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R8 valids low, R4 no select)
    chk(!b_valid && !r_valid, "R8 reset valids", {b_valid, r_valid}, 0);
    chk(apb_sel == 0 && !apb_enable, "R4 reset select", apb_sel, 0);
    chk(aw_ready && w_ready && ar_ready, "R6 reset slots free",
        {aw_ready, w_ready, ar_ready}, 3'b111);

    // vector walk
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      cfg_waits = v.waits; cfg_err = v.err; cfg_noise = v.noise;
      cfg_rd = v.data;
      s0 = sel_cycles; u0 = setup_cycles;
      if (v.wr) present(1, 1, 0, v.addr, v.data, '0);
      else      present(0, 0, 1, '0, '0, v.addr);
      wait_resp(v.wr);
      if (v.wr) chk(b_resp == v.resp, $sformatf("R3 R1 R4 b_resp vec%0d", i), b_resp, v.resp);
      else      chk(r_resp == v.resp, $sformatf("R3 R1 R2 R4 r_resp vec%0d", i), r_resp, v.resp);
      if (v.sel == 0) begin
        chk(sel_cycles == s0, $sformatf("R4 no select on miss vec%0d", i), sel_cycles - s0, 0);
        if (!v.wr) chk(r_data == 0, $sformatf("R4 zero data on miss vec%0d", i), r_data, 0);
      end else begin
        chk(cap_sel == v.sel, $sformatf("R4 select vec%0d", i), cap_sel, v.sel);
        chk(cap_addr == v.addr && cap_wr == v.wr, $sformatf("R5 addr/dir vec%0d", i),
            {cap_wr, cap_addr}, {v.wr, v.addr});
        chk(setup_cycles - u0 == 1, $sformatf("R5 one setup vec%0d", i), setup_cycles - u0, 1);
        if (v.wr) chk(cap_wdata == v.data, $sformatf("R5 wdata vec%0d", i), cap_wdata, v.data);
        else      chk(r_data == v.data, $sformatf("R9 read data vec%0d", i), r_data, v.data);
      end
      @(negedge clk);
    end
    cfg_waits = 0; cfg_err = 0; cfg_noise = 0;

    // R6: address alone must not start a write
    s0 = sel_cycles;
    present(1, 0, 0, 16'h1008, '0, '0);
    repeat (6) @(negedge clk);
    chk(sel_cycles == s0 && !b_valid, "R6 no start without data", sel_cycles - s0, 0);
    present(0, 1, 0, '0, 32'hCAFE_0010, '0);
    wait_resp(1);
    chk(b_resp == 2'b00 && cap_wdata == 32'hCAFE_0010 && cap_addr == 16'h1008,
        "R6 write after data", {b_resp, cap_wdata}, {2'b00, 32'hCAFE_0010});
    @(negedge clk);

    // R8: stalled slave-error response holds
    b_ready = 0; cfg_err = 1;
    present(1, 1, 0, 16'h2008, 32'h1, '0);
    wait_resp(1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(b_valid && b_resp == 2'b10, "R8 held write response", {b_valid, b_resp}, 3'b110);
    end
    b_ready = 1; cfg_err = 0;
    @(negedge clk);
    chk(!b_valid, "R8 released after ready", b_valid, 0);

    // R7: simultaneous pending, read first after reset
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    o0 = ord_n;
    present(1, 1, 1, 16'h0020, 32'h2, 16'h1030);
    while (ord_n < o0 + 2) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ord_log[o0[3:0]] == 0 && ord_log[4'(o0 + 1)] == 1, "R7 read then write",
        {ord_log[o0[3:0]], ord_log[4'(o0 + 1)]}, 2'b01);

    // R7: contention behind a held read response alternates to the write
    r_ready = 0; cfg_rd = 32'h4444_0044;
    o0 = ord_n;
    present(0, 0, 1, '0, '0, 16'h2010);
    wait_resp(0);
    present(1, 1, 1, 16'h0030, 32'h3, 16'h1040);
    repeat (3) @(negedge clk);
    chk(r_valid && r_data == 32'h4444_0044, "R8 read held under stall", r_data, 32'h4444_0044);
    r_ready = 1;
    while (ord_n < o0 + 3) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ord_log[4'(o0 + 1)] == 1 && ord_log[4'(o0 + 2)] == 0, "R7 alternate after read",
        {ord_log[4'(o0 + 1)], ord_log[4'(o0 + 2)]}, 2'b10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule